// File: doc/BRIEF.md
# Persistent Window Threshold Interrupt

This block watches a stream of unsigned conversion results and decides when the light level has left a programmed window for long enough to alert the host. Each accepted result is compared with a low and a high threshold. A result that lies strictly below the low threshold, or strictly above the high one, counts as outside the window. The block counts consecutive outside results. When that count reaches a persistence value chosen by a 2-bit selector, it sets a sticky flag and pulls the active-low interrupt output low.

The flag stays set until the host finishes writing the command register. That event reaches the block as a one-cycle clear strobe. Conversions keep arriving and keep being evaluated while the flag is set. Result input uses valid/ready. The block never applies back-pressure: `res_ready` is held high, and a result is taken on every clock edge where `res_valid` is high and the sensor is active. While the sensor is powered down (`sense_on` low), results are ignored and the run counter is held at zero. Thresholds, the selector and the power state are plain level inputs.

Top module: `lwi_threshold_irq`

## Requirements
- R1: An accepted result is outside the window when it is less than `thr_lo` or greater than `thr_hi`. A result equal to either threshold is inside.
- R2: `persist_sel` sets the number of consecutive outside results needed to trigger: 2'b00 needs 1, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16. The flag rises at the clock edge that accepts the result completing the run.
- R3: An accepted inside result resets the consecutive count to zero.
- R4: Once set, `irq_flag` stays 1 until a clear strobe, whatever results follow.
- R5: `irq_n` is 0 exactly when `irq_flag` is 1.
- R6: A `flag_clr` pulse zeroes both the flag and the consecutive count at the next edge. If a trigger is accepted in the same cycle, the flag is set instead.
- R7: While `sense_on` is 0, results are ignored and the count is held at zero. The flag is kept.
- R8: With the reset thresholds (low 16'h0000, high 16'hFFFF), no result can trigger.
- R9: `res_ready` is 1 at all times after reset. No result is ever stalled.
- R10: Runs longer than the persistence value keep the flag set; the counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A new conversion result is present |
| res_ready | output | 1 | Block can take a result (always 1) |
| res_data | input | 16 | Conversion result |
| thr_lo | input | 16 | Lower window threshold |
| thr_hi | input | 16 | Upper window threshold |
| persist_sel | input | 2 | Consecutive-count selector |
| sense_on | input | 1 | 1 when the sensor is converting, 0 when powered down |
| flag_clr | input | 1 | One-cycle pulse when a command register write completes |
| irq_flag | output | 1 | Sticky interrupt status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A run counter that is wrong shows up at the ports only through the timing of the flag. If the count is too high, the flag rises one or more results too early. If it is too low, or fails to reset, the flag rises late or at the wrong time after an inside result or a clear. So every persistence setting is checked at the result just before the trigger point and at the trigger point itself. A flag that is lost or stuck shows up on `irq_flag` and `irq_n` at the edge right after the clear or the trigger, and that is where it is sampled.

// File: rtl/lwi_pkg.sv
package lwi_pkg;
  localparam int DATA_W      = 16;
  localparam int PERSIST_MAX = 16;
  localparam int CNT_W       = $clog2(PERSIST_MAX + 1);

  typedef logic [CNT_W-1:0] run_cnt_t;

  // Selector to required run length: 1, 4, 8, 16
  function automatic run_cnt_t persist_need(input logic [1:0] sel);
    case (sel)
      2'b00:   return run_cnt_t'(1);
      2'b01:   return run_cnt_t'(4);
      2'b10:   return run_cnt_t'(8);
      default: return run_cnt_t'(PERSIST_MAX);
    endcase
  endfunction
endpackage

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         outside
);
  logic below, above;
  assign below   = value < lo;
  assign above   = value > hi;
  assign outside = below | above;
endmodule

// File: rtl/lwi_persist_ctr.sv
module lwi_persist_ctr #(
  parameter int CNT_W = 5,
  parameter int SAT   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             outside,
  input  logic             active,
  input  logic             clr,
  input  logic [CNT_W-1:0] need,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  logic [CNT_W-1:0] inc;

  assign inc = (cnt == SAT_V) ? cnt : cnt + 1'b1;
  assign hit = take && outside && (inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!active || clr)    cnt <= '0;
    else if (take)              cnt <= outside ? inc : '0;
  end

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == '0);
  a_r3_inside_resets: assert property (@(posedge clk) disable iff (!rst_n)
    take && !outside |=> cnt == '0);
  a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == SAT_V && take && outside && active && !clr |=> cnt == SAT_V);
endmodule

// File: rtl/lwi_flag_reg.sv
module lwi_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  a_r6_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set && clr |=> flag);
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag);
endmodule

// File: rtl/lwi_threshold_irq.sv
module lwi_threshold_irq
  import lwi_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  output logic         res_ready,
  input  logic [W-1:0] res_data,
  input  logic [W-1:0] thr_lo,
  input  logic [W-1:0] thr_hi,
  input  logic [1:0]   persist_sel,
  input  logic         sense_on,
  input  logic         flag_clr,
  output logic         irq_flag,
  output logic         irq_n
);
  logic     take, outside, hit;
  run_cnt_t run_cnt;

  assign res_ready = 1'b1;
  assign take      = res_valid && sense_on;

  lwi_window_cmp #(.W(W)) u_cmp (
    .value(res_data), .lo(thr_lo), .hi(thr_hi), .outside(outside)
  );

  lwi_persist_ctr #(.CNT_W(CNT_W), .SAT(PERSIST_MAX)) u_ctr (
    .clk(clk), .rst_n(rst_n), .take(take), .outside(outside),
    .active(sense_on), .clr(flag_clr), .need(persist_need(persist_sel)),
    .cnt(run_cnt), .hit(hit)
  );

  lwi_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(flag_clr), .flag(irq_flag)
  );

  assign irq_n = ~irq_flag;

  a_r1_below_fires: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && sense_on && persist_sel == 2'b00 && res_data < thr_lo |=> irq_flag);
  a_r7_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_on && !irq_flag |=> !irq_flag);
  a_r8_default_window: assert property (@(posedge clk) disable iff (!rst_n)
    thr_lo == '0 && thr_hi == '1 && !irq_flag |=> !irq_flag);
  a_r2_run_too_short: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag && run_cnt == '0 && persist_sel != 2'b00 |=> !irq_flag);
endmodule

// File: tb/lwi_threshold_irq_tb.sv
module lwi_threshold_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [15:0] res_data = '0;
  logic [15:0] thr_lo = 16'h0000;
  logic [15:0] thr_hi = 16'hFFFF;
  logic [1:0]  persist_sel = 2'b00;
  logic        sense_on = 1'b1;
  logic        flag_clr = 1'b0;
  logic        irq_flag, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lwi_threshold_irq u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .persist_sel(persist_sel), .sense_on(sense_on), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .irq_n(irq_n)
  );

  // {lo, hi, sel, data, repeats, expected flag}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {16'd100, 16'd200,   2'b00, 16'd99,    5'd1,  1'b1},
    {16'd100, 16'd200,   2'b00, 16'd100,   5'd1,  1'b0},
    {16'd100, 16'd200,   2'b00, 16'd200,   5'd1,  1'b0},
    {16'd100, 16'd200,   2'b00, 16'd201,   5'd1,  1'b1},
    {16'd100, 16'd200,   2'b01, 16'd50,    5'd3,  1'b0},
    {16'd100, 16'd200,   2'b01, 16'd50,    5'd4,  1'b1},
    {16'd100, 16'd200,   2'b10, 16'd250,   5'd7,  1'b0},
    {16'd100, 16'd200,   2'b10, 16'd250,   5'd8,  1'b1},
    {16'd100, 16'd200,   2'b11, 16'd0,     5'd15, 1'b0},
    {16'd100, 16'd200,   2'b11, 16'd0,     5'd16, 1'b1},
    {16'h0000, 16'hFFFF, 2'b00, 16'h0000,  5'd1,  1'b0},
    {16'h0000, 16'hFFFF, 2'b00, 16'hFFFF,  5'd1,  1'b0},
    {16'd100, 16'd200,   2'b11, 16'd300,   5'd20, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    check("R4 reset flag", irq_flag, 1'b0);
    check("R5 reset irq_n", irq_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready", res_ready, 1'b1);

    // Table walk: R1, R2, R8, R10
    for (int i = 0; i < NV; i++) begin
      thr_lo      = VEC[i][55:40];
      thr_hi      = VEC[i][39:24];
      persist_sel = VEC[i][23:22];
      pulse_clr();
      for (int k = 0; k < int'(VEC[i][5:1]); k++) send(VEC[i][21:6]);
      check($sformatf("R1/R2/R8/R10 row %0d flag", i), irq_flag, VEC[i][0]);
      check($sformatf("R5 row %0d irq_n", i), irq_n, ~VEC[i][0]);
    end

    // R4: flag stays set over inside results
    thr_lo = 16'd100; thr_hi = 16'd200; persist_sel = 2'b00;
    pulse_clr();
    send(16'd10);
    for (int k = 0; k < 3; k++) send(16'd150);
    check("R4 sticky", irq_flag, 1'b1);
    pulse_clr();
    check("R6 clear drops flag", irq_flag, 1'b0);
    check("R5 irq_n released", irq_n, 1'b1);

    // R3: inside result resets the run
    persist_sel = 2'b01;
    pulse_clr();
    for (int k = 0; k < 3; k++) send(16'd20);
    send(16'd150);
    for (int k = 0; k < 3; k++) send(16'd20);
    check("R3 broken run", irq_flag, 1'b0);
    send(16'd20);
    check("R3 full run after reset", irq_flag, 1'b1);

    // R6: clear restarts the count
    pulse_clr();
    for (int k = 0; k < 3; k++) send(16'd20);
    pulse_clr();
    send(16'd20);
    check("R6 count restarted", irq_flag, 1'b0);
    for (int k = 0; k < 3; k++) send(16'd20);
    check("R6 run after clear", irq_flag, 1'b1);

    // R6: trigger and clear together -> trigger wins
    persist_sel = 2'b00;
    pulse_clr();
    @(negedge clk);
    res_valid = 1'b1; res_data = 16'd5; flag_clr = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; flag_clr = 1'b0;
    check("R6 trigger wins", irq_flag, 1'b1);

    // R7: powered down ignores results and zeroes the count
    persist_sel = 2'b01;
    pulse_clr();
    for (int k = 0; k < 2; k++) send(16'd20);
    sense_on = 1'b0;
    for (int k = 0; k < 6; k++) send(16'd20);
    check("R7 ignored while off", irq_flag, 1'b0);
    sense_on = 1'b1;
    for (int k = 0; k < 3; k++) send(16'd20);
    check("R7 count held zero", irq_flag, 1'b0);
    send(16'd20);
    check("R7 counts after wake", irq_flag, 1'b1);
    sense_on = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 flag kept while off", irq_flag, 1'b1);
    check("R9 ready while off", res_ready, 1'b1);

    finish_run();
  end
endmodule